// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block shifts or rotates the second operand of an ALU in a single clock. It takes a data word, a shift kind, an 8-bit amount and the current carry flag. It returns the shifted word and a carry-out, which is the last bit that left the word. The amount can come from an immediate field or from the low byte of a register. The block only sees the byte, so amounts from 0 to 255 are all legal.

There are five kinds of operation: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry. A left rotate has no mode of its own; the caller asks for a right rotate by the word width minus n. The core is a cascade of log2(WIDTH) stages of 2:1 multiplexers that rotate right. A left shift runs through the same rotator on a bit-reversed copy of the word. A second multiplexer cascade builds the mask of bit positions that keep data rather than fill bits.

The result and the carry-out are registered once. The block has no state machine. Its only states are the reset state, in which both outputs read zero, and the running state, in which the outputs are updated on every clock.

Top module: `bsh_barrel_shift`

## Requirements
- R1: Kind code 0 (logical left) with amount n in 1..31 gives data shifted left with zeros entering bit 0, and carry-out equal to data bit 32-n.
- R2: Kind code 1 (logical right) with n in 1..31 gives zeros entering at bit 31, and carry-out equal to data bit n-1.
- R3: Kind code 2 (arithmetic right) with n in 1..31 fills the vacated top bits with copies of the original bit 31, and carry-out equals data bit n-1.
- R4: Kind code 3 (rotate right) with n in 1..31 moves the bits leaving bit 0 into the top, and carry-out equals result bit 31.
- R5: Kind code 4 (rotate through carry) ignores the amount and gives {carry_in, data[31:1]}, with carry-out equal to data bit 0.
- R6: Kind codes 0 to 3 with an amount of 0 pass the data unchanged, and carry-out equals carry_in.
- R7: An amount of exactly 32 gives a zero result for kind 0 with carry-out equal to data bit 0, and a zero result for kind 1 with carry-out equal to data bit 31.
- R8: An amount above 32 gives a zero result and a zero carry-out for kinds 0 and 1.
- R9: Kind 2 with an amount of 32 or more gives every bit equal to data bit 31, and carry-out equal to data bit 31.
- R10: Kind 3 with an amount of 32 or more rotates by the amount modulo 32. When that remainder is 0, the data is returned unchanged and carry-out equals data bit 31.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge. While rst is high, both outputs read zero.
- R12: Kind codes 5 to 7 pass the data unchanged, and carry-out equals carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_data | input | 32 | Word to shift or rotate |
| op_kind | input | 3 | Shift kind code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate through carry |
| op_amount | input | 8 | Shift amount (immediate or low register byte) |
| carry_in | input | 1 | Current carry flag |
| shift_result | output | 32 | Shifted word, registered |
| carry_out | output | 1 | Last bit shifted out, registered |

## Verification
Every result and carry-out is due exactly one rising edge after its inputs are sampled, whatever the kind and amount. The bench changes the inputs on the falling edge and compares both outputs with a behavioural model at the next falling edge. One comparison is made per clock. The directed vectors cover amounts 0, 1, 31, 32, 33, 63, 64 and 255 for every kind, and a long pseudo-random run follows. A reset asserted in the middle of the run is checked on the falling edge after the rising edge that captured it.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    // Decoded control for one operation
    typedef struct packed {
        logic rrx;        // one-place rotate through carry
        logic pass;       // kind code with no shift behaviour
        logic is_zero;    // amount is zero
        logic full;       // amount >= width
        logic over;       // amount > width
        logic rev;        // run the right-hand core on a bit-reversed word
        logic fill_sign;  // vacated bits take the sign bit
        logic keep_all;   // rotation: no bit is replaced by fill
    } shift_ctl_t;

endpackage

// File: rtl/bsh_amount_decode.sv
module bsh_amount_decode
    import bsh_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [2:0]       kind,
    input  logic [AMT_W-1:0] amount,
    output shift_ctl_t       ctl,
    output logic [LOG_W-1:0] rot_amt
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(WIDTH);

    shift_kind_e kind_e;
    assign kind_e  = shift_kind_e'(kind);
    assign rot_amt = amount[LOG_W-1:0];

    always_comb begin
        ctl           = '0;
        ctl.is_zero   = (amount == '0);
        ctl.full      = (amount >= FULL_AMT);
        ctl.over      = (amount >  FULL_AMT);
        unique case (kind_e)
            SH_LSL: ctl.rev       = 1'b1;
            SH_LSR: ctl.rev       = 1'b0;
            SH_ASR: ctl.fill_sign = 1'b1;
            SH_ROR: ctl.keep_all  = 1'b1;
            SH_RRX: ctl.rrx       = 1'b1;
            default: ctl.pass     = 1'b1;
        endcase
    end

endmodule

// File: rtl/bsh_rotr_cascade.sv
module bsh_rotr_cascade #(
    parameter int WIDTH = 32,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [LOG_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [0:LOG_W];
    assign stage[0] = din;

    for (genvar s = 0; s < LOG_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s]
            ? {stage[s][SH-1:0], stage[s][WIDTH-1:SH]}
            : stage[s];
    end

    assign dout = stage[LOG_W];

endmodule

// File: rtl/bsh_mask_cascade.sv
module bsh_mask_cascade #(
    parameter int WIDTH = 32,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic [LOG_W-1:0] amt,
    output logic [WIDTH-1:0] keep
);

    // A set bit marks a position that still holds data after a right shift
    logic [WIDTH-1:0] stage [0:LOG_W];
    assign stage[0] = '1;

    for (genvar s = 0; s < LOG_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s] ? (stage[s] >> SH) : stage[s];
    end

    assign keep = stage[LOG_W];

endmodule

// File: rtl/bsh_barrel_shift.sv
module bsh_barrel_shift
    import bsh_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int LOG_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_data,
    input  logic [2:0]       op_kind,
    input  logic [AMT_W-1:0] op_amount,
    input  logic             carry_in,
    output logic [WIDTH-1:0] shift_result,
    output logic             carry_out
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(WIDTH);

    shift_ctl_t       ctl;
    logic [LOG_W-1:0] rot_amt;
    logic [WIDTH-1:0] data_rev, core_in, core_rot, keep_m, keep, core, core_rev, post;
    logic             fill_bit;
    logic [WIDTH-1:0] next_res;
    logic             next_co;
    logic [WIDTH-1:0] res_q;
    logic             co_q;
    logic             primed_q;

    bsh_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_dec (
        .kind    (op_kind),
        .amount  (op_amount),
        .ctl     (ctl),
        .rot_amt (rot_amt)
    );

    // Left shifts reuse the right-hand core on a mirrored word
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign data_rev[i] = op_data[WIDTH-1-i];
        assign core_rev[i] = core[WIDTH-1-i];
    end

    assign core_in = ctl.rev ? data_rev : op_data;

    bsh_rotr_cascade #(.WIDTH(WIDTH)) u_rot (
        .din  (core_in),
        .amt  (rot_amt),
        .dout (core_rot)
    );

    bsh_mask_cascade #(.WIDTH(WIDTH)) u_mask (
        .amt  (rot_amt),
        .keep (keep_m)
    );

    always_comb begin
        if (ctl.keep_all)  keep = '1;
        else if (ctl.full) keep = '0;
        else               keep = keep_m;
    end

    assign fill_bit = ctl.fill_sign & op_data[WIDTH-1];
    assign core     = (core_rot & keep) | ({WIDTH{fill_bit}} & ~keep);
    assign post     = ctl.rev ? core_rev : core;

    // Result and carry selection
    always_comb begin
        if (ctl.rrx) begin
            next_res = {carry_in, op_data[WIDTH-1:1]};
            next_co  = op_data[0];
        end else if (ctl.pass || ctl.is_zero) begin
            next_res = op_data;
            next_co  = carry_in;
        end else if (ctl.over && !ctl.keep_all) begin
            next_res = post;
            next_co  = fill_bit;
        end else begin
            next_res = post;
            next_co  = core_rot[WIDTH-1];
        end
    end

    // State register: marks that the previous edge was out of reset
    always_ff @(posedge clk) begin
        if (rst) primed_q <= 1'b0;
        else     primed_q <= 1'b1;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            co_q  <= 1'b0;
        end else begin
            res_q <= next_res;
            co_q  <= next_co;
        end
    end

    assign shift_result = res_q;
    assign carry_out    = co_q;

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (shift_result == '0 && !carry_out));

    // R5
    rrx_path_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_kind) == 3'd4) |->
        (shift_result == {$past(carry_in), $past(op_data[WIDTH-1:1])}
         && carry_out == $past(op_data[0])));

    // R6
    zero_amount_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_amount) == '0 && $past(op_kind) < 3'd4) |->
        (shift_result == $past(op_data) && carry_out == $past(carry_in)));

    // R8
    beyond_width_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_kind) < 3'd2 && $past(op_amount) > FULL_AMT) |->
        (shift_result == '0 && !carry_out));

    // R9
    asr_sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_kind) == 3'd2 && $past(op_amount) >= FULL_AMT) |->
        (shift_result == {WIDTH{$past(op_data[WIDTH-1])}}
         && carry_out == $past(op_data[WIDTH-1])));

    // R4
    ror_ones_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (primed_q && $past(op_kind) == 3'd3) |->
        ($countones(shift_result) == $countones($past(op_data))));

endmodule

// File: tb/tb_bsh_barrel_shift.sv
`timescale 1ns/1ps
module tb_bsh_barrel_shift;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_data = '0;
    logic [2:0]  op_kind = '0;
    logic [7:0]  op_amount = '0;
    logic        carry_in = 1'b0;
    logic [31:0] shift_result;
    logic        carry_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bsh_barrel_shift dut (
        .clk          (clk),
        .rst          (rst),
        .op_data      (op_data),
        .op_kind      (op_kind),
        .op_amount    (op_amount),
        .carry_in     (carry_in),
        .shift_result (shift_result),
        .carry_out    (carry_out)
    );

    // Behavioural model: one bit per step
    task automatic model(input logic [2:0] k, input int n, input logic [31:0] d,
                         input logic ci, output logic [31:0] r, output logic co);
        r  = d;
        co = ci;
        if (k == 3'd4) begin
            r  = {ci, d[31:1]};
            co = d[0];
        end else if (k < 3'd4) begin
            for (int i = 0; i < n; i++) begin
                case (k)
                    3'd0: begin co = r[31]; r = r << 1; end
                    3'd1: begin co = r[0];  r = r >> 1; end
                    3'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
                    default: begin co = r[0]; r = {r[0], r[31:1]}; end
                endcase
            end
        end
    endtask

    function automatic string req_of(input logic [2:0] k, input int n);
        if (k == 3'd4) return "R5";
        if (k > 3'd4)  return "R12";
        if (n == 0)    return "R6";
        if (k == 3'd3) return (n >= 32) ? "R10" : "R4";
        if (k == 3'd2) return (n >= 32) ? "R9" : "R3";
        if (n > 32)    return "R8";
        if (n == 32)   return "R7";
        return (k == 3'd0) ? "R1" : "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] exp_r, input logic exp_c);
        tests++;
        if (shift_result !== exp_r || carry_out !== exp_c) begin
            fails++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     req, shift_result, carry_out, exp_r, exp_c);
        end
    endtask

    // Drive on a falling edge, compare on the next falling edge (R11 latency)
    task automatic apply(input logic [2:0] k, input logic [7:0] n,
                         input logic [31:0] d, input logic ci);
        logic [31:0] er;
        logic        ec;
        op_kind   = k;
        op_amount = n;
        op_data   = d;
        carry_in  = ci;
        model(k, int'(n), d, ci, er, ec);
        @(negedge clk);
        check(req_of(k, int'(n)), er, ec);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: result=%h carry=%b expected run to complete", shift_result, carry_out);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] amts [8] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd63, 8'd64, 8'd255};
        logic [31:0] pats [4] = '{32'h8000_0001, 32'h1234_CDEF, 32'h7FFF_FFFE, 32'hA5C3_0F96};
        repeat (3) @(negedge clk);
        op_data = 32'hFFFF_FFFF; carry_in = 1'b1; op_amount = 8'd5;
        @(negedge clk);
        check("R11", 32'h0, 1'b0);   // reset state
        rst = 1'b0;

        // Directed corners: every kind, every boundary amount
        for (int k = 0; k < 8; k++)
            for (int a = 0; a < 8; a++)
                for (int p = 0; p < 4; p++) begin
                    apply(3'(k), amts[a], pats[p], 1'b0);
                    apply(3'(k), amts[a], pats[p], 1'b1);
                end

        // R1/R2/R3: every amount 1..31
        for (int n = 1; n < 32; n++) begin
            apply(3'd0, 8'(n), 32'hC000_0003, 1'b0);
            apply(3'd1, 8'(n), 32'hC000_0003, 1'b1);
            apply(3'd2, 8'(n), 32'h8000_0001, 1'b0);
            apply(3'd3, 8'(n), 32'h1234_5678, 1'b1);
        end

        // Reset in the middle of a run (R11)
        op_kind = 3'd3; op_amount = 8'd7; op_data = 32'hDEAD_BEEF; carry_in = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R11", 32'h0, 1'b0);
        rst = 1'b0;

        // Pseudo-random run
        for (int i = 0; i < 4000; i++)
            apply(3'($urandom_range(0, 7)), 8'($urandom), $urandom, 1'($urandom));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule